// File: doc/BRIEF.md
# Five-Port Wormhole Mesh Router with XY and YX Virtual Channels

This block is one switching node of a two-dimensional on-chip mesh. It has five ports: a local port towards the attached core, and one port towards each compass neighbour. Every port carries one flit per clock, tagged with a virtual-channel number. Two virtual channels share each link, flit by flit, and each has its own input buffer and its own credit counter. Channel 0 is the dimension-ordered class, which finishes every X hop before any Y hop. Channel 1 is an escape class, which resolves Y first and X second.

A head flit is routed once and claims an output virtual channel. It keeps that channel until its tail flit leaves, and the body flits follow without being routed again. If the head of an XY-class packet finds its XY output channel owned by another packet, the router moves the packet into the YX class, provided the matching YX output channel is free. From then on the packet travels in YX order. Each output port has a round-robin arbiter that picks one ready input channel per cycle. When a flit leaves an input buffer, a credit is returned upstream on the same virtual channel.

Top module: `mesh_router`

## Requirements
- R1: A flit is DATA_W+2 bits wide. Bit DATA_W+1 marks a tail and bit DATA_W marks a head, so the codes are 00 body, 01 head, 10 tail and 11 single-flit packet. In a head flit, bits [2:0] hold the destination X, bits [5:3] the destination Y and bit 6 the class.
- R2: A head arriving on input channel 0 is routed X first. The port is east if dest X > MY_X and west if dest X < MY_X. If X matches, the port is north if dest Y > MY_Y and south if dest Y < MY_Y. If both match, the port is local. The packet leaves on channel 0 when that channel is free.
- R3: A head arriving on input channel 1 is routed Y first. The port is north or south while Y differs, then east or west, then local. The packet leaves on channel 1.
- R4: An XY-class head whose XY output channel is owned by another packet takes the YX output channel of its YX route if that channel is free. The class bit of the forwarded head then reads 1.
- R5: An output channel stays owned by one packet from its head until its tail. Body flits follow that packet whatever their content. A head that needs an owned channel waits, and flits within one channel keep their order.
- R6: Each output channel holds a credit count that starts at CREDITS. A flit is sent only while the count is nonzero, and each in_credit pulse adds one.
- R7: out_credit[2*p+v] pulses for one cycle for every flit removed from input buffer (port p, channel v).
- R8: Each output port grants at most one input channel per cycle, and the previous winner gets the lowest priority in the next cycle.
- R9: During reset all out_valid and out_credit bits are 0.
- R10: Each input channel buffers BUF_DEPTH flits, and no flit written within that capacity is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 5 | Flit present on input port p (0 local, 1 east, 2 west, 3 north, 4 south) |
| in_vc | input | 5 | Virtual channel of the incoming flit on each port |
| in_flit | input | 5*(DATA_W+2) | Incoming flits, port p in slice p |
| out_credit | output | 10 | Credit returned upstream, bit 2*p+v |
| out_valid | output | 5 | Flit present on output port p |
| out_vc | output | 5 | Virtual channel of the outgoing flit on each port |
| out_flit | output | 5*(DATA_W+2) | Outgoing flits, port p in slice p |
| in_credit | input | 10 | Credit returned from downstream, bit 2*p+v |

## Verification
The bench places the router at coordinates (3,3), so every destination in the 3-bit grid lies on one side of it or the other, and each of the five output ports can be reached in both classes. The credit depth is set to 2, small enough that withholding credits stalls a channel after two flits. The buffer depth is set to 4, which holds a whole four-flit packet during that stall. A body payload of all ones decodes as coordinates (7,7), so a body flit that was routed again would leave on the wrong port.

// File: rtl/mesh_noc_pkg.sv
package mesh_noc_pkg;
  localparam int NPORTS  = 5;
  localparam int NVCS    = 2;
  localparam int COORD_W = 3;

  localparam logic [2:0] P_LOCAL = 3'd0;
  localparam logic [2:0] P_EAST  = 3'd1;
  localparam logic [2:0] P_WEST  = 3'd2;
  localparam logic [2:0] P_NORTH = 3'd3;
  localparam logic [2:0] P_SOUTH = 3'd4;

  localparam int DX_LSB  = 0;
  localparam int DY_LSB  = 3;
  localparam int CLS_BIT = 6;

  // X resolved before Y
  function automatic logic [2:0] route_xy(input logic [COORD_W-1:0] cx, input logic [COORD_W-1:0] cy,
                                          input logic [COORD_W-1:0] dx, input logic [COORD_W-1:0] dy);
    if (dx > cx)      return P_EAST;
    else if (dx < cx) return P_WEST;
    else if (dy > cy) return P_NORTH;
    else if (dy < cy) return P_SOUTH;
    else              return P_LOCAL;
  endfunction

  // Y resolved before X
  function automatic logic [2:0] route_yx(input logic [COORD_W-1:0] cx, input logic [COORD_W-1:0] cy,
                                          input logic [COORD_W-1:0] dx, input logic [COORD_W-1:0] dy);
    if (dy > cy)      return P_NORTH;
    else if (dy < cy) return P_SOUTH;
    else if (dx > cx) return P_EAST;
    else if (dx < cx) return P_WEST;
    else              return P_LOCAL;
  endfunction
endpackage

// File: rtl/vc_fifo.sv
module vc_fifo #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/rr_arbiter.sv
module rr_arbiter #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] ptr;
  logic [PW-1:0] win;

  always_comb begin
    gnt = '0;
    win = '0;
    for (int k = 0; k < N; k++) begin
      if (gnt == '0 && req[(int'(ptr) + k) % N]) begin
        gnt[(int'(ptr) + k) % N] = 1'b1;
        win = PW'((int'(ptr) + k) % N);
      end
    end
  end

  // the slot after the winner becomes the highest priority
  always_ff @(posedge clk) begin
    if (!rst_n)      ptr <= '0;
    else if (|req)   ptr <= (win == PW'(N - 1)) ? '0 : win + 1'b1;
  end
endmodule

// File: rtl/credit_counter.sv
module credit_counter #(
  parameter int MAX = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       inc,
  input  logic                       dec,
  output logic                       nz,
  output logic [$clog2(MAX+1)-1:0]   count
);
  localparam int CW = $clog2(MAX + 1);

  assign nz = (count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) count <= CW'(MAX);
    else        count <= count + CW'(inc) - CW'(dec);
  end
endmodule

// File: rtl/mesh_router.sv
module mesh_router
  import mesh_noc_pkg::*;
#(
  parameter int MY_X      = 3,
  parameter int MY_Y      = 3,
  parameter int DATA_W    = 16,
  parameter int BUF_DEPTH = 4,
  parameter int CREDITS   = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NPORTS-1:0]               in_valid,
  input  logic [NPORTS-1:0]               in_vc,
  input  logic [NPORTS*(DATA_W+2)-1:0]    in_flit,
  output logic [NPORTS*NVCS-1:0]          out_credit,
  output logic [NPORTS-1:0]               out_valid,
  output logic [NPORTS-1:0]               out_vc,
  output logic [NPORTS*(DATA_W+2)-1:0]    out_flit,
  input  logic [NPORTS*NVCS-1:0]          in_credit
);
  localparam int FLIT_W = DATA_W + 2;
  localparam int NIVC   = NPORTS * NVCS;
  localparam int CNT_W  = $clog2(CREDITS + 1);

  // input channel state
  logic [FLIT_W-1:0] q_flit [NIVC];
  logic [NIVC-1:0]   q_empty, q_full, q_push, q_pop;
  logic [NIVC-1:0]   q_is_head, q_is_tail;
  logic [2:0]        rt_xy [NIVC];
  logic [2:0]        rt_yx [NIVC];
  logic [NIVC-1:0]   alloc_ok, alloc_vc;
  logic [2:0]        alloc_port [NIVC];

  // output channel state
  logic [NIVC-1:0]   ovc_busy, ovc_send, cred_nz;
  logic [CNT_W-1:0]  cred_cnt [NIVC];

  // channel allocation results
  logic [NIVC-1:0]   va_win, va_vc, va_taken;
  logic [2:0]        va_port [NIVC];

  // switch arbitration, port o in slice o
  logic [NPORTS*NIVC-1:0] sw_req_flat, sw_gnt_flat;

  for (genvar i = 0; i < NIVC; i++) begin : g_in
    localparam int P = i / NVCS;
    localparam int V = i % NVCS;

    assign q_push[i] = in_valid[P] && (int'(in_vc[P]) == V);

    vc_fifo #(.WIDTH(FLIT_W), .DEPTH(BUF_DEPTH)) u_buf (
      .clk(clk), .rst_n(rst_n), .push(q_push[i]), .din(in_flit[P*FLIT_W +: FLIT_W]),
      .pop(q_pop[i]), .dout(q_flit[i]), .empty(q_empty[i]), .full(q_full[i])
    );

    assign q_is_head[i] = q_flit[i][FLIT_W-2];
    assign q_is_tail[i] = q_flit[i][FLIT_W-1];
    assign rt_xy[i] = route_xy(COORD_W'(MY_X), COORD_W'(MY_Y),
                               q_flit[i][DX_LSB +: COORD_W], q_flit[i][DY_LSB +: COORD_W]);
    assign rt_yx[i] = route_yx(COORD_W'(MY_X), COORD_W'(MY_Y),
                               q_flit[i][DX_LSB +: COORD_W], q_flit[i][DY_LSB +: COORD_W]);

    // one counter per output channel slot 2*port+vc
    credit_counter #(.MAX(CREDITS)) u_cred (
      .clk(clk), .rst_n(rst_n), .inc(in_credit[i]), .dec(ovc_send[i]),
      .nz(cred_nz[i]), .count(cred_cnt[i])
    );
  end

  // Output channel allocation: lower input index claims first within a cycle.
  // XY-class heads try their XY channel, then escape to the YX channel.
  always_comb begin
    va_taken = ovc_busy;
    va_win   = '0;
    va_vc    = '0;
    for (int i = 0; i < NIVC; i++) va_port[i] = P_LOCAL;
    for (int i = 0; i < NIVC; i++) begin
      if (!q_empty[i] && !alloc_ok[i] && q_is_head[i]) begin
        if ((i % NVCS) == 0 && !va_taken[int'(rt_xy[i])*NVCS]) begin
          va_win[i]  = 1'b1;
          va_port[i] = rt_xy[i];
          va_vc[i]   = 1'b0;
          va_taken[int'(rt_xy[i])*NVCS] = 1'b1;
        end else if (!va_taken[int'(rt_yx[i])*NVCS + 1]) begin
          va_win[i]  = 1'b1;
          va_port[i] = rt_yx[i];
          va_vc[i]   = 1'b1;
          va_taken[int'(rt_yx[i])*NVCS + 1] = 1'b1;
        end
      end
    end
  end

  for (genvar o = 0; o < NPORTS; o++) begin : g_out
    logic [NIVC-1:0]   req, gnt;
    logic [FLIT_W-1:0] sel_f;
    logic              sel_v;
    logic              ov_q, ovc_q;
    logic [FLIT_W-1:0] of_q;

    always_comb begin
      for (int k = 0; k < NIVC; k++)
        req[k] = alloc_ok[k] && (alloc_port[k] == 3'(o)) && !q_empty[k]
                 && cred_nz[o*NVCS + int'(alloc_vc[k])];
    end

    rr_arbiter #(.N(NIVC)) u_arb (.clk(clk), .rst_n(rst_n), .req(req), .gnt(gnt));

    assign sw_req_flat[o*NIVC +: NIVC] = req;
    assign sw_gnt_flat[o*NIVC +: NIVC] = gnt;

    always_comb begin
      sel_f = '0;
      sel_v = 1'b0;
      for (int k = 0; k < NIVC; k++) begin
        if (gnt[k]) begin
          sel_f = q_flit[k];
          sel_v = alloc_vc[k];
        end
      end
      if (sel_f[FLIT_W-2]) sel_f[CLS_BIT] = sel_v;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ov_q  <= 1'b0;
        ovc_q <= 1'b0;
        of_q  <= '0;
      end else begin
        ov_q  <= |gnt;
        ovc_q <= sel_v;
        of_q  <= sel_f;
      end
    end

    assign out_valid[o]                = ov_q;
    assign out_vc[o]                   = ovc_q;
    assign out_flit[o*FLIT_W +: FLIT_W] = of_q;
  end

  always_comb begin
    q_pop = '0;
    for (int o = 0; o < NPORTS; o++)
      for (int k = 0; k < NIVC; k++)
        if (sw_gnt_flat[o*NIVC + k]) q_pop[k] = 1'b1;
  end

  always_comb begin
    ovc_send = '0;
    for (int k = 0; k < NIVC; k++)
      if (q_pop[k]) ovc_send[int'(alloc_port[k])*NVCS + int'(alloc_vc[k])] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alloc_ok   <= '0;
      alloc_vc   <= '0;
      ovc_busy   <= '0;
      out_credit <= '0;
      for (int k = 0; k < NIVC; k++) alloc_port[k] <= P_LOCAL;
    end else begin
      out_credit <= q_pop;
      for (int k = 0; k < NIVC; k++) begin
        if (q_pop[k] && q_is_tail[k]) begin
          alloc_ok[k] <= 1'b0;
          ovc_busy[int'(alloc_port[k])*NVCS + int'(alloc_vc[k])] <= 1'b0;
        end
      end
      for (int k = 0; k < NIVC; k++) begin
        if (va_win[k]) begin
          alloc_ok[k]   <= 1'b1;
          alloc_port[k] <= va_port[k];
          alloc_vc[k]   <= va_vc[k];
          ovc_busy[int'(va_port[k])*NVCS + int'(va_vc[k])] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/router_checker.sv
module router_checker
  import mesh_noc_pkg::*;
#(
  parameter int MY_X   = 3,
  parameter int MY_Y   = 3,
  parameter int DATA_W = 16
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NPORTS-1:0]            out_valid,
  input logic [NPORTS-1:0]            out_vc,
  input logic [NPORTS*(DATA_W+2)-1:0] out_flit,
  input logic [NPORTS*NVCS-1:0]       out_credit,
  input logic [NPORTS*NVCS-1:0]       q_push,
  input logic [NPORTS*NVCS-1:0]       q_full,
  input logic [NPORTS*NVCS-1:0]       q_empty,
  input logic [NPORTS*NVCS-1:0]       ovc_send,
  input logic [NPORTS*NVCS-1:0]       cred_nz,
  input logic [NPORTS*NPORTS*NVCS-1:0] sw_req_flat,
  input logic [NPORTS*NPORTS*NVCS-1:0] sw_gnt_flat
);
  localparam int FW   = DATA_W + 2;
  localparam int NIVC = NPORTS * NVCS;

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (q_push & q_full) == '0);

  for (genvar s = 0; s < NIVC; s++) begin : g_slot
    p_credit_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ovc_send[s] |-> cred_nz[s]);
    p_credit_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_credit[s] |-> $past(!q_empty[s]));
  end

  for (genvar o = 0; o < NPORTS; o++) begin : g_port
    localparam bit IS_VERT  = (o == 3) || (o == 4);
    localparam bit IS_HORIZ = (o == 1) || (o == 2);
    logic [FW-1:0]       f;
    logic [NIVC-1:0]     req, gnt;
    assign f   = out_flit[o*FW +: FW];
    assign req = sw_req_flat[o*NIVC +: NIVC];
    assign gnt = sw_gnt_flat[o*NIVC +: NIVC];

    p_onehot_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
    p_rr_rotate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(|gnt) && |(req & ~$past(gnt))) |-> ((gnt & $past(gnt)) == '0));
    p_xy_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (IS_VERT && out_valid[o] && !out_vc[o] && f[FW-2]) |-> (f[DX_LSB +: COORD_W] == COORD_W'(MY_X)));
    p_yx_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (IS_HORIZ && out_valid[o] && out_vc[o] && f[FW-2]) |-> (f[DY_LSB +: COORD_W] == COORD_W'(MY_Y)));
  end
endmodule

bind mesh_router router_checker #(.MY_X(MY_X), .MY_Y(MY_Y), .DATA_W(DATA_W)) u_checker (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_vc(out_vc), .out_flit(out_flit),
  .out_credit(out_credit), .q_push(q_push), .q_full(q_full), .q_empty(q_empty),
  .ovc_send(ovc_send), .cred_nz(cred_nz), .sw_req_flat(sw_req_flat), .sw_gnt_flat(sw_gnt_flat)
);

// File: tb/tb_mesh_router.sv
module tb_mesh_router;
  localparam int DATA_W = 16;
  localparam int FW     = DATA_W + 2;
  localparam int NP     = 5;
  localparam int NS     = 10;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NP-1:0]  in_valid = '0;
  logic [NP-1:0]  in_vc = '0;
  logic [NP*FW-1:0] in_flit = '0;
  logic [NS-1:0]  out_credit;
  logic [NP-1:0]  out_valid;
  logic [NP-1:0]  out_vc;
  logic [NP*FW-1:0] out_flit;
  logic [NS-1:0]  in_credit = '0;

  always #4 clk = ~clk;

  mesh_router #(.MY_X(3), .MY_Y(3), .DATA_W(DATA_W), .BUF_DEPTH(4), .CREDITS(2)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vc(in_vc), .in_flit(in_flit),
    .out_credit(out_credit), .out_valid(out_valid), .out_vc(out_vc), .out_flit(out_flit),
    .in_credit(in_credit)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  string cur_req = "R9";

  logic [FW-1:0] expq [NS][$];
  int sent_cnt [NS];
  int up_cnt   [NS];
  int seen_cnt [NS];
  int owed     [NS];
  bit hold     [NS];
  bit rr_watch = 0;
  bit rr_vc [$];

  task automatic check(input bit ok, input string req, input longint act, input longint exp_v);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  function automatic logic [FW-1:0] hd(input int dx, input int dy, input int cls, input bit tail);
    logic [FW-1:0] f = '0;
    f[FW-1] = tail;
    f[FW-2] = 1'b1;
    f[2:0]  = 3'(dx);
    f[5:3]  = 3'(dy);
    f[6]    = cls[0];
    return f;
  endfunction

  function automatic logic [FW-1:0] bd(input logic [DATA_W-1:0] d, input bit tail);
    logic [FW-1:0] f = '0;
    f[FW-1] = tail;
    f[DATA_W-1:0] = d;
    return f;
  endfunction

  task automatic expect_at(input int port, input int vc, input logic [FW-1:0] f);
    expq[port*2+vc].push_back(f);
  endtask

  task automatic put(input int p, input int v, input logic [FW-1:0] f);
    in_valid[p] = 1'b1;
    in_vc[p] = v[0];
    in_flit[p*FW +: FW] = f;
    sent_cnt[p*2+v]++;
  endtask

  task automatic step();
    @(negedge clk);
    in_valid = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) step();
  endtask

  task automatic drain(input string req);
    int left;
    idle(15);
    left = 0;
    for (int s = 0; s < NS; s++) left += expq[s].size();
    check(left == 0, req, left, 0);
  endtask

  // monitor: compares outputs and plays the downstream credit return
  always @(negedge clk) begin
    if (rst_n) begin
      for (int o = 0; o < NP; o++) begin
        if (out_valid[o]) begin
          int s;
          logic [FW-1:0] got, want;
          s = o*2 + int'(out_vc[o]);
          got = out_flit[o*FW +: FW];
          seen_cnt[s]++;
          owed[s]++;
          if (rr_watch && o == 1) rr_vc.push_back(out_vc[o]);
          if (expq[s].size() == 0) begin
            check(1'b0, cur_req, longint'(got), 0);
          end else begin
            want = expq[s].pop_front();
            check(got == want, cur_req, longint'(got), longint'(want));
          end
        end
      end
      for (int i = 0; i < NS; i++) if (out_credit[i]) up_cnt[i]++;
      for (int s = 0; s < NS; s++) begin
        if (owed[s] > 0 && !hold[s]) begin
          in_credit[s] = 1'b1;
          owed[s]--;
        end else begin
          in_credit[s] = 1'b0;
        end
      end
    end
  end

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired in %s", cur_req);
      report();
    end
  end

  initial begin
    for (int s = 0; s < NS; s++) begin
      sent_cnt[s] = 0; up_cnt[s] = 0; seen_cnt[s] = 0; owed[s] = 0; hold[s] = 0;
    end
    repeat (3) @(negedge clk);
    // R9: outputs quiet in reset
    check(out_valid == '0, "R9", longint'(out_valid), 0);
    check(out_credit == '0, "R9", longint'(out_credit), 0);
    rst_n = 1'b1;
    step();

    // R2 with R1 encoding: XY class from the local port
    cur_req = "R2";
    put(0, 0, hd(5, 1, 0, 1)); expect_at(1, 0, hd(5, 1, 0, 1)); step(); idle(6);
    put(0, 0, hd(1, 6, 0, 1)); expect_at(2, 0, hd(1, 6, 0, 1)); step(); idle(6);
    put(0, 0, hd(3, 6, 0, 1)); expect_at(3, 0, hd(3, 6, 0, 1)); step(); idle(6);
    put(0, 0, hd(3, 0, 0, 1)); expect_at(4, 0, hd(3, 0, 0, 1)); step(); idle(6);
    put(4, 0, hd(3, 3, 0, 1)); expect_at(0, 0, hd(3, 3, 0, 1)); step();
    drain("R2");

    // R3: YX class, Y resolved first
    cur_req = "R3";
    put(0, 1, hd(5, 6, 1, 1)); expect_at(3, 1, hd(5, 6, 1, 1)); step(); idle(6);
    put(0, 1, hd(1, 0, 1, 1)); expect_at(4, 1, hd(1, 0, 1, 1)); step(); idle(6);
    put(0, 1, hd(6, 3, 1, 1)); expect_at(1, 1, hd(6, 3, 1, 1)); step(); idle(6);
    put(0, 1, hd(0, 3, 1, 1)); expect_at(2, 1, hd(0, 3, 1, 1)); step();
    drain("R3");

    // R5 / R1: body of all ones follows its head to the west port
    cur_req = "R5";
    put(0, 0, hd(0, 3, 0, 0)); expect_at(2, 0, hd(0, 3, 0, 0)); step();
    put(0, 0, bd(16'hFFFF, 0)); expect_at(2, 0, bd(16'hFFFF, 0)); step();
    put(0, 0, bd(16'hFFFF, 1)); expect_at(2, 0, bd(16'hFFFF, 1)); step();
    drain("R5");

    // R4: east channel 0 held open; an XY head escapes to north channel 1
    cur_req = "R4";
    put(2, 0, hd(5, 3, 0, 0)); expect_at(1, 0, hd(5, 3, 0, 0)); step();
    put(2, 0, bd(16'h1234, 0)); expect_at(1, 0, bd(16'h1234, 0)); step();
    idle(8);
    put(0, 0, hd(5, 5, 0, 1)); expect_at(3, 1, hd(5, 5, 1, 1)); step();
    idle(8);
    check(expq[3*2+1].size() == 0, "R4", expq[3*2+1].size(), 0);
    put(2, 0, bd(16'h5678, 1)); expect_at(1, 0, bd(16'h5678, 1)); step();
    drain("R4");

    // R5: a YX head waits while east channel 1 is owned
    cur_req = "R5";
    begin
      int base;
      base = seen_cnt[3];
      put(3, 1, hd(5, 3, 1, 0)); expect_at(1, 1, hd(5, 3, 1, 0)); step();
      idle(2);
      put(4, 1, hd(6, 3, 1, 1)); step();
      idle(10);
      check(seen_cnt[3] - base == 1, "R5", seen_cnt[3] - base, 1);
      put(3, 1, bd(16'h00AA, 1)); expect_at(1, 1, bd(16'h00AA, 1));
      expect_at(1, 1, hd(6, 3, 1, 1)); step();
      drain("R5");
    end

    // R6: credits withheld stall east channel 0 after CREDITS flits (R10 holds all four)
    cur_req = "R6";
    begin
      int base;
      base = seen_cnt[2];
      hold[2] = 1;
      put(0, 0, hd(4, 3, 0, 0)); expect_at(1, 0, hd(4, 3, 0, 0)); step();
      put(0, 0, bd(16'h0001, 0)); expect_at(1, 0, bd(16'h0001, 0)); step();
      put(0, 0, bd(16'h0002, 0)); expect_at(1, 0, bd(16'h0002, 0)); step();
      put(0, 0, bd(16'h0003, 1)); expect_at(1, 0, bd(16'h0003, 1)); step();
      idle(20);
      check(seen_cnt[2] - base == 2, "R6", seen_cnt[2] - base, 2);
      hold[2] = 0;
      drain("R10");
      check(seen_cnt[2] - base == 4, "R10", seen_cnt[2] - base, 4);
    end

    // R8: two streams on the east port alternate channels
    cur_req = "R8";
    rr_watch = 1;
    put(0, 0, hd(5, 3, 0, 0)); expect_at(1, 0, hd(5, 3, 0, 0));
    put(2, 1, hd(5, 3, 1, 0)); expect_at(1, 1, hd(5, 3, 1, 0)); step();
    for (int k = 1; k < 4; k++) begin
      put(0, 0, bd(16'(16'h0100 + k), k == 3)); expect_at(1, 0, bd(16'(16'h0100 + k), k == 3));
      put(2, 1, bd(16'(16'h0200 + k), k == 3)); expect_at(1, 1, bd(16'(16'h0200 + k), k == 3));
      step();
    end
    drain("R8");
    rr_watch = 0;
    check(rr_vc.size() == 8, "R8", rr_vc.size(), 8);
    for (int k = 1; k < 8 && k < rr_vc.size(); k++)
      check(rr_vc[k] != rr_vc[k-1], "R8", rr_vc[k], !rr_vc[k-1]);

    // R7: one upstream credit per flit taken from each input channel
    cur_req = "R7";
    for (int s = 0; s < NS; s++)
      check(up_cnt[s] == sent_cnt[s], "R7", up_cnt[s], sent_cnt[s]);

    done = 1;
    report();
  end
endmodule